// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Compare Alarm

This block keeps wall-clock time as an unsigned count of seconds and presents it to a host over a narrow byte-wide register bus. An external once-per-second strobe advances the count while counting is switched on. A compare bank holds an alarm time. When the count steps onto that value while the alarm is armed, a sticky flag is set and an interrupt line is raised.

Software sets the time by writing the three upper staging bytes first. It then writes the lowest byte, and that write moves all four bytes into the counter in the same cycle. Reads see the live count directly, with no snapshot. A reader who wants a consistent value reads the low byte a second time and repeats the sequence if it went down. Counting and alarm arming share one control byte. The alarm flag is cleared by writing a zero to its bit.

Top module: `sec_rtc_top`

## Requirements
- R1: After reset every register offset reads 0x00 and `alarm_irq` is low.
- R2: When counting is enabled (control offset 0, bit 7 = 1) and `tick_1hz` is high for a cycle with no commit in that cycle, the count increases by exactly one. Carries propagate across bytes. The count is read little-endian at offsets 6..9, with offset 6 the least significant byte.
- R3: While control bit 7 is 0, ticks leave the count unchanged.
- R4: Writes to offsets 3, 4 and 5 set staged bytes 1, 2 and 3 and do not change the count. A write to offset 2 loads {staged byte 3, staged byte 2, staged byte 1, written data} into the count in one cycle.
- R5: A commit through offset 2 in the same cycle as an enabled tick loads the written value, and the increment is dropped.
- R6: An enabled tick at count 0xFFFFFFFF gives a count of 0x00000000.
- R7: The alarm compare value is read and written little-endian at offsets 10..13, with offset 10 the least significant byte.
- R8: The alarm fires when counting is enabled, the alarm is armed (control bit 1 = 1), and an applied tick makes the new count equal the compare value. Firing sets status bit 0 at offset 1. `alarm_irq` equals status bit 0 AND control bit 1. With the alarm disarmed, the flag is never set.
- R9: The status bit stays set until a write to offset 1 with data bit 0 = 0. A write with data bit 0 = 1 has no effect on it. Disarming the alarm drops `alarm_irq` but keeps the status bit.
- R10: The control register reads back only bits 7 and 1, and all other bits read 0. Offsets 2..5 and 14..15 read 0x00. Writes to offsets 6..9 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle strobe once per second |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| alarm_irq | output | 1 | Level alarm interrupt |

## Verification
Two situations are hard to reach from the ports by counting up from reset. One is the wrap from the all-ones count to zero. The other is an alarm firing on that wrap. The stimulus gets to both by committing 0xFFFFFFFF through the staged write and then applying one tick, with and without an armed compare value of zero. A commit that lands in the same cycle as a tick is driven on purpose, to show that the load wins. A long pseudo-random phase mixes writes, reads and ticks, and every cycle is compared against a behavioural model.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

   // control byte bit positions
   localparam int unsigned CTL_RUN_BIT = 7;
   localparam int unsigned CTL_ARM_BIT = 1;
   // status byte bit position
   localparam int unsigned STS_HIT_BIT = 0;

   // fixed register offsets ahead of the byte banks
   localparam int unsigned OFS_CTL = 0;
   localparam int unsigned OFS_STS = 1;

   typedef struct packed {
      logic run;
      logic arm;
   } rtc_ctl_t;

endpackage

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt_q,
   output logic             step,
   output logic [CNT_W-1:0] cnt_inc
);

   // a load always wins over an increment in the same cycle
   assign step    = tick && run && !load;
   assign cnt_inc = cnt_q + CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (step) begin
         cnt_q <= cnt_inc;
      end
   end

endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic [CNT_W-1:0] cnt_inc,
   input  logic [CNT_W-1:0] cmp_val,
   input  logic             arm,
   input  logic             hit_clr,
   output logic             hit_q,
   output logic             irq
);

   logic fire;

   assign fire = step && arm && (cnt_inc == cmp_val);

   // a new hit outranks a software clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_q <= 1'b0;
      end else if (fire) begin
         hit_q <= 1'b1;
      end else if (hit_clr) begin
         hit_q <= 1'b0;
      end
   end

   assign irq = hit_q && arm;

endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
   import rtc_pkg::*;
#(
   parameter int unsigned BYTE_W  = 8,
   parameter int unsigned N_BYTES = 4,
   parameter int unsigned ADDR_W  = 4,
   parameter int unsigned WR_BASE = 2,
   parameter int unsigned RD_BASE = 6,
   parameter int unsigned AL_BASE = 10,
   localparam int unsigned CNT_W  = BYTE_W * N_BYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [BYTE_W-1:0] bus_wdata,
   input  logic [CNT_W-1:0]  cnt_q,
   input  logic              hit_q,
   output rtc_ctl_t          ctl,
   output logic              load,
   output logic [CNT_W-1:0]  load_val,
   output logic [CNT_W-1:0]  cmp_val,
   output logic              hit_clr,
   output logic [BYTE_W-1:0] bus_rdata
);

   logic [N_BYTES-1:0] stg_hit;
   logic [N_BYTES-1:0] alw_hit;
   logic [BYTE_W-1:0]  stg_byte [N_BYTES];
   logic [BYTE_W-1:0]  cmp_byte [N_BYTES];
   logic               ctl_wr;

   assign ctl_wr  = bus_wr && (bus_addr == ADDR_W'(OFS_CTL));
   assign hit_clr = bus_wr && (bus_addr == ADDR_W'(OFS_STS)) && !bus_wdata[STS_HIT_BIT];
   assign load    = stg_hit[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl <= '0;
      end else if (ctl_wr) begin
         ctl.run <= bus_wdata[CTL_RUN_BIT];
         ctl.arm <= bus_wdata[CTL_ARM_BIT];
      end
   end

   for (genvar g = 0; g < N_BYTES; g++) begin : g_lane
      assign stg_hit[g] = bus_wr && (bus_addr == ADDR_W'(WR_BASE + g));
      assign alw_hit[g] = bus_wr && (bus_addr == ADDR_W'(AL_BASE + g));

      if (g == 0) begin : g_commit_lane
         // the low byte is never stored: its write is the commit
         assign stg_byte[g] = bus_wdata;
      end else begin : g_staged_lane
         logic [BYTE_W-1:0] stg_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stg_q <= '0;
            end else if (stg_hit[g]) begin
               stg_q <= bus_wdata;
            end
         end
         assign stg_byte[g] = stg_q;
      end

      logic [BYTE_W-1:0] cmp_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cmp_q <= '0;
         end else if (alw_hit[g]) begin
            cmp_q <= bus_wdata;
         end
      end
      assign cmp_byte[g] = cmp_q;

      assign load_val[g*BYTE_W +: BYTE_W] = stg_byte[g];
      assign cmp_val[g*BYTE_W +: BYTE_W]  = cmp_byte[g];
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(OFS_CTL)) begin
         bus_rdata[CTL_RUN_BIT] = ctl.run;
         bus_rdata[CTL_ARM_BIT] = ctl.arm;
      end
      if (bus_addr == ADDR_W'(OFS_STS)) begin
         bus_rdata[STS_HIT_BIT] = hit_q;
      end
      for (int i = 0; i < int'(N_BYTES); i++) begin
         if (bus_addr == ADDR_W'(RD_BASE + i)) begin
            bus_rdata = cnt_q[i*BYTE_W +: BYTE_W];
         end
         if (bus_addr == ADDR_W'(AL_BASE + i)) begin
            bus_rdata = cmp_byte[i];
         end
      end
   end

endmodule

// File: rtl/sec_rtc_top.sv
module sec_rtc_top
   import rtc_pkg::*;
#(
   parameter int unsigned BYTE_W  = 8,
   parameter int unsigned N_BYTES = 4,
   parameter int unsigned ADDR_W  = 4,
   localparam int unsigned CNT_W   = BYTE_W * N_BYTES,
   localparam int unsigned WR_BASE = OFS_STS + 1,
   localparam int unsigned RD_BASE = WR_BASE + N_BYTES,
   localparam int unsigned AL_BASE = RD_BASE + N_BYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_1hz,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [BYTE_W-1:0] bus_wdata,
   output logic [BYTE_W-1:0] bus_rdata,
   output logic              alarm_irq
);

   if (BYTE_W < 8) begin : g_bad_byte_w
      $error("sec_rtc_top: BYTE_W must hold control bit 7");
   end
   if (N_BYTES < 1) begin : g_bad_n_bytes
      $error("sec_rtc_top: N_BYTES must be at least 1");
   end
   if (AL_BASE + N_BYTES > (1 << ADDR_W)) begin : g_bad_addr_w
      $error("sec_rtc_top: ADDR_W too narrow for the register banks");
   end

   rtc_ctl_t         ctl;
   logic             run;
   logic             arm;
   logic             load;
   logic [CNT_W-1:0] load_val;
   logic [CNT_W-1:0] cmp_val;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_inc;
   logic             step;
   logic             hit_q;
   logic             hit_clr;

   assign run = ctl.run;
   assign arm = ctl.arm;

   rtc_regfile #(
      .BYTE_W (BYTE_W),
      .N_BYTES(N_BYTES),
      .ADDR_W (ADDR_W),
      .WR_BASE(WR_BASE),
      .RD_BASE(RD_BASE),
      .AL_BASE(AL_BASE)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_addr (bus_addr),
      .bus_wr   (bus_wr),
      .bus_wdata(bus_wdata),
      .cnt_q    (cnt_q),
      .hit_q    (hit_q),
      .ctl      (ctl),
      .load     (load),
      .load_val (load_val),
      .cmp_val  (cmp_val),
      .hit_clr  (hit_clr),
      .bus_rdata(bus_rdata)
   );

   rtc_sec_counter #(
      .CNT_W(CNT_W)
   ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick_1hz),
      .run     (run),
      .load    (load),
      .load_val(load_val),
      .cnt_q   (cnt_q),
      .step    (step),
      .cnt_inc (cnt_inc)
   );

   rtc_alarm_unit #(
      .CNT_W(CNT_W)
   ) u_alm (
      .clk    (clk),
      .rst_n  (rst_n),
      .step   (step),
      .cnt_inc(cnt_inc),
      .cmp_val(cmp_val),
      .arm    (arm),
      .hit_clr(hit_clr),
      .hit_q  (hit_q),
      .irq    (alarm_irq)
   );

endmodule

// File: rtl/rtc_chk.sv
module rtc_chk #(
   parameter int unsigned CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic             run,
   input logic             arm,
   input logic             load,
   input logic [CNT_W-1:0] load_val,
   input logic [CNT_W-1:0] cmp_val,
   input logic [CNT_W-1:0] cnt_q,
   input logic             hit_q,
   input logic             hit_clr,
   input logic             irq
);

   a_r2_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && run && !load && cnt_q != '1) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

   a_r3_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !load) |=> $stable(cnt_q));

   a_r5_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> cnt_q == $past(load_val));

   a_r6_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && run && !load && cnt_q == '1) |=> cnt_q == '0);

   a_r8_hit_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hit_q) |-> ($past(arm) && $past(run) && $past(tick) && cnt_q == $past(cmp_val)));

   a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (arm && hit_q));

   a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_q && !hit_clr) |=> hit_q);

endmodule

bind sec_rtc_top rtc_chk #(.CNT_W(CNT_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .tick    (tick_1hz),
   .run     (run),
   .arm     (arm),
   .load    (load),
   .load_val(load_val),
   .cmp_val (cmp_val),
   .cnt_q   (cnt_q),
   .hit_q   (hit_q),
   .hit_clr (hit_clr),
   .irq     (alarm_irq)
);

// File: tb/sec_rtc_top_tb_top.sv
`timescale 1ns/1ps
module sec_rtc_top_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int MAX_CYCLES = 200000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_1hz = 1'b0;
   logic [3:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       alarm_irq;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sec_rtc_top dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_1hz (tick_1hz),
      .bus_addr (bus_addr),
      .bus_wr   (bus_wr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .alarm_irq(alarm_irq)
   );

   // ---------------- behavioural reference model ----------------
   logic [31:0] m_time, m_cmp, m_next;
   logic [7:0]  m_stage [4];
   bit          m_run, m_arm, m_flag, m_adv, m_hit, m_wipe, m_commit;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_time = 0; m_cmp = 0; m_run = 0; m_arm = 0; m_flag = 0;
         foreach (m_stage[k]) m_stage[k] = 8'h00;
      end else begin
         m_commit = bus_wr && bus_addr == 4'd2;
         m_adv    = tick_1hz && m_run && !m_commit;
         m_next   = m_time + 32'd1;
         m_hit    = m_adv && m_arm && (m_next == m_cmp);
         m_wipe   = bus_wr && bus_addr == 4'd1 && bus_wdata[0] == 1'b0;
         if (m_commit)
            m_time = {m_stage[3], m_stage[2], m_stage[1], bus_wdata};
         else if (m_adv)
            m_time = m_next;
         if (m_hit) m_flag = 1;
         else if (m_wipe) m_flag = 0;
         if (bus_wr) begin
            case (bus_addr)
               4'd0: begin m_run = bus_wdata[7]; m_arm = bus_wdata[1]; end
               4'd3: m_stage[1] = bus_wdata;
               4'd4: m_stage[2] = bus_wdata;
               4'd5: m_stage[3] = bus_wdata;
               4'd10: m_cmp[7:0]   = bus_wdata;
               4'd11: m_cmp[15:8]  = bus_wdata;
               4'd12: m_cmp[23:16] = bus_wdata;
               4'd13: m_cmp[31:24] = bus_wdata;
               default: ;
            endcase
         end
      end
   end

   function automatic logic [7:0] model_rd(input logic [3:0] a);
      case (a)
         4'd0: return {m_run, 5'b0, m_arm, 1'b0};
         4'd1: return {7'b0, m_flag};
         4'd6: return m_time[7:0];
         4'd7: return m_time[15:8];
         4'd8: return m_time[23:16];
         4'd9: return m_time[31:24];
         4'd10: return m_cmp[7:0];
         4'd11: return m_cmp[15:8];
         4'd12: return m_cmp[23:16];
         4'd13: return m_cmp[31:24];
         default: return 8'h00;
      endcase
   endfunction

   function automatic string tag_of(input logic [3:0] a);
      if (a == 4'd1) return "R9";
      if (a >= 4'd6 && a <= 4'd9) return "R2";
      if (a >= 4'd10 && a <= 4'd13) return "R7";
      return "R10";
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk(tag_of(bus_addr), {24'b0, bus_rdata}, {24'b0, model_rd(bus_addr)});
         chk("R8 irq", {31'b0, alarm_irq}, {31'b0, m_flag && m_arm});
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic cyc(input logic [3:0] a, input bit w, input logic [7:0] d, input bit t);
      @(negedge clk); #1;
      bus_addr = a; bus_wr = w; bus_wdata = d; tick_1hz = t;
   endtask

   task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
      cyc(a, 1'b1, d, 1'b0);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) cyc(4'd0, 1'b0, 8'h00, 1'b1);
   endtask

   task automatic rd_expect(input logic [3:0] a, input logic [7:0] exp, input string tag);
      cyc(a, 1'b0, 8'h00, 1'b0);
      @(negedge clk);
      chk(tag, {24'b0, bus_rdata}, {24'b0, exp});
   endtask

   task automatic irq_expect(input bit exp, input string tag);
      cyc(4'd0, 1'b0, 8'h00, 1'b0);
      @(negedge clk);
      chk(tag, {31'b0, alarm_irq}, {31'b0, exp});
   endtask

   task automatic load_time(input logic [31:0] v);
      wr_reg(4'd3, v[15:8]);
      wr_reg(4'd4, v[23:16]);
      wr_reg(4'd5, v[31:24]);
      wr_reg(4'd2, v[7:0]);
   endtask

   task automatic set_cmp(input logic [31:0] v);
      wr_reg(4'd10, v[7:0]);
      wr_reg(4'd11, v[15:8]);
      wr_reg(4'd12, v[23:16]);
      wr_reg(4'd13, v[31:24]);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (MAX_CYCLES) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++; errors++;
         $display("FAIL watchdog actual=running expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   // ---------------- directed and random stimulus ----------------
   initial begin
      logic [31:0] lf;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: every offset reads zero after reset
      for (int a = 0; a < 16; a++) rd_expect(4'(a), 8'h00, "R1");
      irq_expect(1'b0, "R1 irq");

      // R4: staged bytes do not touch the count until the low byte
      wr_reg(4'd3, 8'h12); wr_reg(4'd4, 8'h34); wr_reg(4'd5, 8'h56);
      rd_expect(4'd9, 8'h00, "R4 staged only");
      wr_reg(4'd2, 8'h78);
      rd_expect(4'd6, 8'h78, "R4 byte0");
      rd_expect(4'd7, 8'h12, "R4 byte1");
      rd_expect(4'd8, 8'h34, "R4 byte2");
      rd_expect(4'd9, 8'h56, "R4 byte3");

      // R3: ticks ignored while counting is off
      ticks(3);
      rd_expect(4'd6, 8'h78, "R3");

      // R10: control read-back
      wr_reg(4'd0, 8'hFF);
      rd_expect(4'd0, 8'h82, "R10 ctl mask");
      wr_reg(4'd0, 8'h80);
      rd_expect(4'd0, 8'h80, "R10 ctl run");

      // R2: counting
      ticks(3);
      rd_expect(4'd6, 8'h7B, "R2 count");

      // R10: read bank ignores writes, write bank and unmapped read zero
      wr_reg(4'd6, 8'hAA);
      rd_expect(4'd6, 8'h7B, "R10 ro bank");
      rd_expect(4'd3, 8'h00, "R10 write bank");
      rd_expect(4'd14, 8'h00, "R10 unmapped");

      // R2: carry across bytes
      load_time(32'h0000_00FF);
      ticks(1);
      rd_expect(4'd6, 8'h00, "R2 carry lo");
      rd_expect(4'd7, 8'h01, "R2 carry hi");

      // R5: commit with simultaneous tick
      load_time(32'h0000_0000);
      cyc(4'd2, 1'b1, 8'h10, 1'b1);
      rd_expect(4'd6, 8'h10, "R5");

      // R6: wrap
      load_time(32'hFFFF_FFFF);
      ticks(1);
      rd_expect(4'd9, 8'h00, "R6 top");
      rd_expect(4'd6, 8'h00, "R6 low");

      // R7: compare bank
      set_cmp(32'h0000_0005);
      rd_expect(4'd10, 8'h05, "R7 lo");
      rd_expect(4'd13, 8'h00, "R7 hi");

      // R8: fire
      load_time(32'h0000_0003);
      wr_reg(4'd0, 8'h82);
      ticks(1);
      rd_expect(4'd1, 8'h00, "R8 no early fire");
      ticks(1);
      rd_expect(4'd1, 8'h01, "R8 fired");
      irq_expect(1'b1, "R8 irq high");

      // R9: sticky, write-one ignored, disarm drops irq only
      wr_reg(4'd1, 8'hFF);
      rd_expect(4'd1, 8'h01, "R9 w1 ignored");
      ticks(1);
      rd_expect(4'd1, 8'h01, "R9 sticky");
      wr_reg(4'd0, 8'h80);
      irq_expect(1'b0, "R9 disarm irq");
      rd_expect(4'd1, 8'h01, "R9 flag kept");
      wr_reg(4'd1, 8'h00);
      rd_expect(4'd1, 8'h00, "R9 cleared");

      // R8: disarmed never fires
      set_cmp(32'h0000_0007);
      ticks(1);
      rd_expect(4'd6, 8'h07, "R8 count at cmp");
      rd_expect(4'd1, 8'h00, "R8 disarmed");

      // R8 with R6: fire on wrap to zero
      set_cmp(32'h0000_0000);
      load_time(32'hFFFF_FFFF);
      wr_reg(4'd0, 8'h82);
      ticks(1);
      rd_expect(4'd1, 8'h01, "R8 wrap fire");
      irq_expect(1'b1, "R8 wrap irq");
      wr_reg(4'd1, 8'h00);

      // random phase, compared against the model every cycle
      set_cmp(32'h0000_0040);
      load_time(32'h0000_0020);
      wr_reg(4'd0, 8'h82);
      lf = 32'h1D87_2B41;
      for (int n = 0; n < 4000; n++) begin
         lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
         if (lf[7:4] == 4'd0)
            cyc(lf[11:8], 1'b1, lf[23:16], lf[24]);
         else
            cyc(lf[11:8], 1'b0, 8'h00, lf[24]);
      end
      cyc(4'd0, 1'b0, 8'h00, 1'b0);
      @(negedge clk);

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule